// File: doc/BRIEF.md
# Selectable-Sign Multiply-Accumulate Unit

This block multiplies two 16-bit operands and holds the result in a 35-bit register. The 32-bit product can replace the held value, be added to it, or have the held value taken away from it. The operands can be read as unsigned magnitudes or as two's complement numbers, and the choice is made at run time. Three guard bits above the product let a running sum grow past one product without overflowing. An optional rounding constant of 2^15 can be added to every update, so that the upper fields come out rounded to the nearest value.

The X operand, the Y operand and the result each load on their own clock-enable strobe, and all three share one system clock. The four control bits are accumulate, subtract, round and two's-complement mode. They load whenever either operand strobe is high. The result is presented as three fields: a 3-bit extension field (bits 34..32), a high half (bits 31..16) and a low half (bits 15..0). Each field has its own active-low output enable, and tristate pins are modelled as a data output plus an output-enable flag.

In preload mode every field output is switched off. On the result strobe, each field whose enable input is high loads data from its own pins. The low-half preload data arrives on the same input port as the Y operand. The result register has five update modes:
- HOLD: no result strobe, so the register keeps its value.
- MUL: replace the value with the product.
- ADD: add the product to the held value.
- SUB: store the product minus the held value.
- LOAD: preload fields from the pins.

Top module: `fmac_top`

## Requirements
- R1: With tc=1 both operands are two's complement; with tc=0 both are unsigned. For example, 0xFFFF x 0xFFFF gives 0x0FFFE0001 unsigned and 1 signed.
- R2: With acc=0 the result becomes the product, and sub has no effect. Bits 34..32 are the product's sign extension when tc=1 and zero when tc=0.
- R3: With acc=1 and sub=0, the result strobe stores the held value plus the product.
- R4: With acc=1 and sub=1, the result strobe stores the product minus the held value.
- R5: With rnd=1, 2^15 is added to the stored value in MUL, ADD and SUB. With rnd=0 nothing is added.
- R6: x_q loads only on x_stb and y_q only on y_stb. The control bits load when x_stb or y_stb is high. The result register changes only on p_stb.
- R7: Bits 34..32 appear on ext_out, bits 31..16 on hi_out and bits 15..0 on lo_out. Each field's oe output is 1 exactly when preload=0 and that field's active-low enable input is 0.
- R8: While preload=1 all three oe outputs are 0. On p_stb, a field whose enable input is 1 loads from its pins, and a field whose enable input is 0 keeps its value.
- R9: The low-half preload data and the Y operand share the input lo_y_in.
- R10: With tc=1, 0x8000 x 0x8000 gives +2^30 (0x040000000).
- R11: A synchronous reset clears the operand, control and result registers to zero.
- R12: Results wrap modulo 2^35, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| x_stb | input | 1 | X operand load strobe (also loads the controls) |
| y_stb | input | 1 | Y operand load strobe (also loads the controls) |
| p_stb | input | 1 | Result register load strobe |
| x_in | input | 16 | X operand |
| lo_y_in | input | 16 | Y operand; also the low-half preload data |
| ctl_acc | input | 1 | Accumulate select |
| ctl_sub | input | 1 | Subtract select (used only when accumulating) |
| ctl_rnd | input | 1 | Round select |
| ctl_tc | input | 1 | Two's complement operand mode |
| preload | input | 1 | Preload mode |
| ext_en_n | input | 1 | Extension field enable, active low |
| hi_en_n | input | 1 | High half enable, active low |
| lo_en_n | input | 1 | Low half enable, active low |
| ext_pin_in | input | 3 | Extension field preload data |
| hi_pin_in | input | 16 | High half preload data |
| ext_out | output | 3 | Result bits 34..32 |
| ext_oe | output | 1 | Extension field drive enable |
| hi_out | output | 16 | Result bits 31..16 |
| hi_oe | output | 1 | High half drive enable |
| lo_out | output | 16 | Result bits 15..0 |
| lo_oe | output | 1 | Low half drive enable |

## Verification
The hardest case to reach from the ports is carry out of the guard bits. Products alone cannot fill all 35 bits quickly. The stimulus therefore preloads all ones into every field and then accumulates 1 x 1, which must wrap to zero. A mixed preload is also hard to arrange: one field is loaded while its neighbour's enable is low. The neighbour's pins carry a distinct pattern, so any leak into it shows up when the fields are read back.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    typedef struct packed {
        logic acc;
        logic sub;
        logic rnd;
        logic tc;
    } mac_ctl_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_MUL,
        OP_ADD,
        OP_SUB,
        OP_LOAD
    } res_op_e;

endpackage

// File: rtl/fmac_operand_regs.sv
module fmac_operand_regs
    import fmac_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           x_stb,
    input  logic           y_stb,
    input  logic [OPW-1:0] x_in,
    input  logic [OPW-1:0] y_in,
    input  mac_ctl_t       ctl_in,
    output logic [OPW-1:0] x_q,
    output logic [OPW-1:0] y_q,
    output mac_ctl_t       ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= '0;
            ctl_q <= '0;
        end else begin
            if (x_stb) x_q <= x_in;
            if (y_stb) y_q <= y_in;
            if (x_stb || y_stb) ctl_q <= ctl_in;
        end
    end

    // R6: each operand register holds without its own strobe
    a_r6_x_hold: assert property (@(posedge clk) disable iff (rst)
        !x_stb |=> $stable(x_q));
    a_r6_y_hold: assert property (@(posedge clk) disable iff (rst)
        !y_stb |=> $stable(y_q));
    a_r6_ctl_hold: assert property (@(posedge clk) disable iff (rst)
        (!x_stb && !y_stb) |=> $stable(ctl_q));

endmodule

// File: rtl/fmac_product.sv
module fmac_product #(
    parameter int OPW   = 16,
    parameter int GUARD = 3
) (
    input  logic [OPW-1:0]           x,
    input  logic [OPW-1:0]           y,
    input  logic                     tc,
    output logic [2*OPW+GUARD-1:0]   prod
);

    localparam int EXW  = OPW + 1;
    localparam int FULW = 2 * EXW;
    localparam int AW   = 2 * OPW + GUARD;

    logic signed [EXW-1:0]  xs;
    logic signed [EXW-1:0]  ys;
    logic signed [FULW-1:0] full;

    // one extra top bit per operand: copy of the sign in signed mode, zero otherwise
    assign xs   = {tc & x[OPW-1], x};
    assign ys   = {tc & y[OPW-1], y};
    assign full = xs * ys;

    generate
        if (AW > FULW) begin : g_extend
            assign prod = {{(AW-FULW){full[FULW-1]}}, full};
        end else begin : g_trim
            assign prod = full[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/fmac_result_reg.sv
module fmac_result_reg
    import fmac_pkg::*;
#(
    parameter int OPW   = 16,
    parameter int GUARD = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    p_stb,
    input  logic                    preload,
    input  logic                    ext_en_n,
    input  logic                    hi_en_n,
    input  logic                    lo_en_n,
    input  mac_ctl_t                ctl,
    input  logic [2*OPW+GUARD-1:0]  prod,
    input  logic [GUARD-1:0]        pin_ext,
    input  logic [OPW-1:0]          pin_hi,
    input  logic [OPW-1:0]          pin_lo,
    output logic [2*OPW+GUARD-1:0]  acc_q
);

    localparam int PW = 2 * OPW;
    localparam int AW = PW + GUARD;

    res_op_e          op;
    logic [AW-1:0]    rnd_add;
    logic [AW-1:0]    acc_d;

    assign rnd_add = ctl.rnd ? AW'(1) << (OPW - 1) : '0;

    always_comb begin
        if (!p_stb)        op = OP_HOLD;
        else if (preload)  op = OP_LOAD;
        else if (!ctl.acc) op = OP_MUL;
        else if (ctl.sub)  op = OP_SUB;
        else               op = OP_ADD;
    end

    always_comb begin
        acc_d = acc_q;
        unique case (op)
            OP_HOLD: acc_d = acc_q;
            OP_MUL:  acc_d = prod + rnd_add;
            OP_ADD:  acc_d = acc_q + prod + rnd_add;
            OP_SUB:  acc_d = prod - acc_q + rnd_add;
            OP_LOAD: begin
                if (ext_en_n) acc_d[AW-1:PW]  = pin_ext;
                if (hi_en_n)  acc_d[PW-1:OPW] = pin_hi;
                if (lo_en_n)  acc_d[OPW-1:0]  = pin_lo;
            end
            default: acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    // R11: the register is empty in the cycle after reset
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> acc_q == '0);
    // R6: the register holds without the result strobe
    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        !p_stb |=> $stable(acc_q));
    // R3: add form
    a_r3_add_form: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !preload && ctl.acc && !ctl.sub && !ctl.rnd)
        |=> acc_q == $past(AW'(acc_q + prod)));
    // R4: subtract form
    a_r4_sub_form: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !preload && ctl.acc && ctl.sub && !ctl.rnd)
        |=> acc_q == $past(AW'(prod - acc_q)));
    // R8: enabled fields keep their content in preload
    a_r8_lo_kept: assert property (@(posedge clk) disable iff (rst)
        (p_stb && preload && !lo_en_n)
        |=> acc_q[OPW-1:0] == $past(acc_q[OPW-1:0]));
    a_r8_hi_loaded: assert property (@(posedge clk) disable iff (rst)
        (p_stb && preload && hi_en_n)
        |=> acc_q[PW-1:OPW] == $past(pin_hi));

endmodule

// File: rtl/fmac_top.sv
module fmac_top
    import fmac_pkg::*;
#(
    parameter int OPW   = 16,
    parameter int GUARD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             x_stb,
    input  logic             y_stb,
    input  logic             p_stb,
    input  logic [OPW-1:0]   x_in,
    input  logic [OPW-1:0]   lo_y_in,
    input  logic             ctl_acc,
    input  logic             ctl_sub,
    input  logic             ctl_rnd,
    input  logic             ctl_tc,
    input  logic             preload,
    input  logic             ext_en_n,
    input  logic             hi_en_n,
    input  logic             lo_en_n,
    input  logic [GUARD-1:0] ext_pin_in,
    input  logic [OPW-1:0]   hi_pin_in,
    output logic [GUARD-1:0] ext_out,
    output logic             ext_oe,
    output logic [OPW-1:0]   hi_out,
    output logic             hi_oe,
    output logic [OPW-1:0]   lo_out,
    output logic             lo_oe
);

    localparam int PW = 2 * OPW;
    localparam int AW = PW + GUARD;

    mac_ctl_t       ctl_in;
    mac_ctl_t       ctl_q;
    logic [OPW-1:0] x_q;
    logic [OPW-1:0] y_q;
    logic [AW-1:0]  prod;
    logic [AW-1:0]  acc_q;

    assign ctl_in = '{acc: ctl_acc, sub: ctl_sub, rnd: ctl_rnd, tc: ctl_tc};

    fmac_operand_regs #(.OPW(OPW)) u_ops (
        .clk    (clk),
        .rst    (rst),
        .x_stb  (x_stb),
        .y_stb  (y_stb),
        .x_in   (x_in),
        .y_in   (lo_y_in),
        .ctl_in (ctl_in),
        .x_q    (x_q),
        .y_q    (y_q),
        .ctl_q  (ctl_q)
    );

    fmac_product #(.OPW(OPW), .GUARD(GUARD)) u_mul (
        .x    (x_q),
        .y    (y_q),
        .tc   (ctl_q.tc),
        .prod (prod)
    );

    fmac_result_reg #(.OPW(OPW), .GUARD(GUARD)) u_res (
        .clk      (clk),
        .rst      (rst),
        .p_stb    (p_stb),
        .preload  (preload),
        .ext_en_n (ext_en_n),
        .hi_en_n  (hi_en_n),
        .lo_en_n  (lo_en_n),
        .ctl      (ctl_q),
        .prod     (prod),
        .pin_ext  (ext_pin_in),
        .pin_hi   (hi_pin_in),
        .pin_lo   (lo_y_in),
        .acc_q    (acc_q)
    );

    assign ext_out = acc_q[AW-1:PW];
    assign hi_out  = acc_q[PW-1:OPW];
    assign lo_out  = acc_q[OPW-1:0];
    assign ext_oe  = !preload && !ext_en_n;
    assign hi_oe   = !preload && !hi_en_n;
    assign lo_oe   = !preload && !lo_en_n;

    // R2: an unsigned plain multiply leaves the guard bits at zero
    a_r2_unsigned_ext_zero: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !preload && !ctl_q.acc && !ctl_q.tc && !ctl_q.rnd)
        |=> ext_out == '0);
    // R2: a signed plain multiply gives guard bits that all equal bit 31
    a_r2_signed_ext: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !preload && !ctl_q.acc && ctl_q.tc && !ctl_q.rnd)
        |=> (ext_out == {GUARD{hi_out[OPW-1]}}));

endmodule

// File: tb/fmac_top_tb.sv
module fmac_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        x_stb, y_stb, p_stb;
    logic [15:0] x_in, lo_y_in, hi_pin_in;
    logic        ctl_acc, ctl_sub, ctl_rnd, ctl_tc;
    logic        preload, ext_en_n, hi_en_n, lo_en_n;
    logic [2:0]  ext_pin_in;
    logic [2:0]  ext_out;
    logic [15:0] hi_out, lo_out;
    logic        ext_oe, hi_oe, lo_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fmac_top u_dut (
        .clk(clk), .rst(rst), .x_stb(x_stb), .y_stb(y_stb), .p_stb(p_stb),
        .x_in(x_in), .lo_y_in(lo_y_in), .ctl_acc(ctl_acc), .ctl_sub(ctl_sub),
        .ctl_rnd(ctl_rnd), .ctl_tc(ctl_tc), .preload(preload),
        .ext_en_n(ext_en_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
        .ext_pin_in(ext_pin_in), .hi_pin_in(hi_pin_in),
        .ext_out(ext_out), .ext_oe(ext_oe), .hi_out(hi_out), .hi_oe(hi_oe),
        .lo_out(lo_out), .lo_oe(lo_oe)
    );

    function automatic logic [34:0] result();
        return {ext_out, hi_out, lo_out};
    endfunction

    task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic load_ops(input logic [15:0] x, input logic [15:0] y,
                            input logic acc, input logic sub,
                            input logic rnd, input logic tc);
        @(negedge clk);
        x_in = x; lo_y_in = y;
        ctl_acc = acc; ctl_sub = sub; ctl_rnd = rnd; ctl_tc = tc;
        x_stb = 1'b1; y_stb = 1'b1;
        @(negedge clk);
        x_stb = 1'b0; y_stb = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        p_stb = 1'b1;
        @(negedge clk);
        p_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset result", result(), 35'h0);
        chk("R7 oe after reset", {32'h0, ext_oe, hi_oe, lo_oe}, 35'h7);
    endtask

    task automatic t_modes();
        load_ops(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        fire();
        chk("R1 R2 unsigned FFFFxFFFF", result(), 35'h0FFFE0001);
        load_ops(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1);
        fire();
        chk("R1 signed -1x-1", result(), 35'h1);
        load_ops(16'hFFFF, 16'h0003, 1'b0, 1'b1, 1'b0, 1'b1);
        fire();
        chk("R2 signed -3 sign ext, sub ignored", result(), 35'h7FFFFFFFD);
        load_ops(16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1);
        fire();
        chk("R10 signed 8000x8000", result(), 35'h040000000);
    endtask

    task automatic t_accumulate();
        logic [34:0] e;
        load_ops(16'd100, 16'd200, 1'b0, 1'b0, 1'b0, 1'b0);
        fire();
        load_ops(16'd3, 16'd5, 1'b1, 1'b0, 1'b0, 1'b0);
        fire();
        chk("R3 add 3x5", result(), 35'd20015);
        load_ops(16'hFFFE, 16'd7, 1'b1, 1'b0, 1'b0, 1'b1);
        fire();
        chk("R3 add signed -2x7", result(), 35'd20001);
        load_ops(16'd10, 16'd10, 1'b1, 1'b1, 1'b0, 1'b0);
        fire();
        e = 35'd100 - 35'd20001;
        chk("R4 product minus held", result(), e);
    endtask

    task automatic t_round();
        load_ops(16'h0001, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b0);
        fire();
        chk("R5 round carries into high half", result(), 35'h000010000);
        load_ops(16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        fire();
        chk("R5 no round adds nothing", result(), 35'h1);
    endtask

    task automatic t_strobes();
        load_ops(16'd5, 16'd6, 1'b0, 1'b0, 1'b0, 1'b0);
        fire();
        chk("R6 base 5x6", result(), 35'd30);
        @(negedge clk);
        x_in = 16'd7; lo_y_in = 16'd100; ctl_acc = 1'b1;
        x_stb = 1'b1;
        @(negedge clk);
        x_stb = 1'b0;
        chk("R6 no p_stb keeps result", result(), 35'd30);
        fire();
        chk("R6 x only reloaded, acc taken with x_stb", result(), 35'd72);
        @(negedge clk);
        ctl_acc = 1'b0;
        @(negedge clk);
        fire();
        chk("R6 controls not loaded without strobe", result(), 35'd114);
        ctl_acc = 1'b0;
    endtask

    task automatic t_enables();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {ext_en_n, hi_en_n, lo_en_n} = 3'(i);
            #1;
            chk("R7 oe follows active-low enables",
                {32'h0, ext_oe, hi_oe, lo_oe}, {32'h0, ~(3'(i))});
        end
        @(negedge clk);
        preload = 1'b1;
        {ext_en_n, hi_en_n, lo_en_n} = 3'b000;
        #1;
        chk("R8 preload turns all outputs off", {32'h0, ext_oe, hi_oe, lo_oe}, 35'h0);
        preload = 1'b0;
    endtask

    task automatic t_preload();
        load_ops(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        fire();
        @(negedge clk);
        preload = 1'b1;
        ext_en_n = 1'b1; hi_en_n = 1'b0; lo_en_n = 1'b1;
        ext_pin_in = 3'd5; hi_pin_in = 16'hAAAA; lo_y_in = 16'hBEEF;
        fire();
        preload = 1'b0; ext_en_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        #1;
        chk("R8 R9 mixed preload", result(), {3'd5, 16'hFFFE, 16'hBEEF});
    endtask

    task automatic t_wrap();
        @(negedge clk);
        preload = 1'b1;
        ext_en_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1;
        ext_pin_in = 3'h7; hi_pin_in = 16'hFFFF; lo_y_in = 16'hFFFF;
        fire();
        preload = 1'b0; ext_en_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        chk("R8 full preload", result(), 35'h7FFFFFFFF);
        load_ops(16'd1, 16'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        fire();
        chk("R12 wrap to zero", result(), 35'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        x_stb = 1'b0; y_stb = 1'b0; p_stb = 1'b0;
        x_in = '0; lo_y_in = '0; hi_pin_in = '0; ext_pin_in = '0;
        ctl_acc = 1'b0; ctl_sub = 1'b0; ctl_rnd = 1'b0; ctl_tc = 1'b0;
        preload = 1'b0; ext_en_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_modes();
        t_accumulate();
        t_round();
        t_strobes();
        t_enables();
        t_preload();
        t_wrap();
        summary();
        $finish;
    end

endmodule